// File: doc/BRIEF.md
# Receive Descriptor Ring Threshold Monitor

This block watches the receive descriptor ring each time a packet has finished landing in host memory. From the ring length, the count of descriptors still available in the ring, and the used and unused counts held in the on-chip descriptor cache, it decides which housekeeping actions the receive path should take next. The possible actions are a low-descriptor interrupt, a forced writeback, a threshold writeback, a descriptor prefetch, a fetch and a stop of the receive engine.

Every decision is made from the input values in the cycle that carries the packet-done strobe. Each action comes out as a one-cycle registered pulse on the next clock. The fetch and writeback DMA engines that act on these pulses are outside this block.

Top module: `rx_ring_monitor`

## Requirements
- R1: After reset, and in any cycle that does not directly follow a packet-done strobe, all request outputs are 0. Each request is a pulse one cycle long, registered on the clock edge that samples the strobe.
- R2: The low-descriptor alarm pulses when the descriptors left are at or below a fraction of the ring length picked by the 2-bit select: select 0 gives length/2, select 1 gives length/4 and select 2 gives length/8 (integer shifts).
- R3: Select value 3 never raises the low-descriptor alarm.
- R4: The low 7 bits of the ring length input are treated as zero.
- R5: When the descriptors left equal 0, both a forced writeback and a stop are requested.
- R6: A threshold writeback is requested when the writeback threshold is greater than or equal to the used cached count.
- R7: A prefetch is requested when the unused cached count is below the prefetch threshold and the descriptors left exceed the unused count by more than the host threshold. A left count smaller than the unused count never qualifies.
- R8: When the unused cached count is 0, both a fetch and a stop are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_done_i | input | 1 | Packet-done strobe, one cycle |
| ring_len_i | input | LEN_W | Programmed ring length in descriptors |
| desc_left_i | input | LEN_W | Descriptors still available in the ring |
| cache_used_i | input | CACHE_W | Used descriptors in the cache |
| cache_unused_i | input | CACHE_W | Unused descriptors in the cache |
| min_sel_i | input | 2 | Low-descriptor fraction select |
| pf_thresh_i | input | CACHE_W | Prefetch threshold |
| host_thresh_i | input | CACHE_W | Host-side threshold |
| wb_thresh_i | input | CACHE_W | Writeback threshold |
| low_irq_o | output | 1 | Low-descriptor interrupt request |
| force_wb_o | output | 1 | Forced writeback request |
| thr_wb_o | output | 1 | Threshold writeback request |
| prefetch_o | output | 1 | Prefetch request |
| fetch_o | output | 1 | Fetch request, cache empty |
| stop_o | output | 1 | Stop the receive engine |

## Verification
The block keeps one register stage and no other state, so a wrong decision shows on the request outputs exactly one cycle after the strobe, and a stuck bit shows as a pulse in a quiet cycle. The bench sweeps every select value over aligned and unaligned lengths. It places the left count just below, at and just above each fraction, and also at zero and at small values. It crosses this with all small combinations of the cache counts and thresholds. It checks every output on the strobe's response cycle and again on the cycle after it.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {
    MT_HALF    = 2'd0,
    MT_QUARTER = 2'd1,
    MT_EIGHTH  = 2'd2,
    MT_OFF     = 2'd3
  } min_sel_e;

  typedef struct packed {
    logic low_irq;
    logic force_wb;
    logic thr_wb;
    logic prefetch;
    logic fetch;
    logic stop;
  } ring_req_t;

  localparam int unsigned LEN_ALIGN = 7;
endpackage

// File: rtl/ring_lowmark.sv
module ring_lowmark
  import rx_ring_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic [LEN_W-1:0] ring_len_i,
  input  logic [LEN_W-1:0] desc_left_i,
  input  logic [1:0]       min_sel_i,
  output logic             low_o
);
  localparam int unsigned NFRAC = 3;

  logic [LEN_W-1:0] len_aligned;
  logic [NFRAC-1:0] below;

  // low bits of the programmed length are not stored
  assign len_aligned = {ring_len_i[LEN_W-1:LEN_ALIGN], LEN_ALIGN'(0)};

  for (genvar k = 0; k < NFRAC; k++) begin : g_frac
    logic [LEN_W-1:0] frac;
    assign frac     = len_aligned >> (k + 1);
    assign below[k] = (desc_left_i <= frac);
  end

  always_comb begin
    unique case (min_sel_e'(min_sel_i))
      MT_HALF:    low_o = below[0];
      MT_QUARTER: low_o = below[1];
      MT_EIGHTH:  low_o = below[2];
      default:    low_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ring_cache_policy.sv
module ring_cache_policy
  import rx_ring_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned CACHE_W = 6
) (
  input  logic [LEN_W-1:0]   desc_left_i,
  input  logic [CACHE_W-1:0] cache_used_i,
  input  logic [CACHE_W-1:0] cache_unused_i,
  input  logic [CACHE_W-1:0] pf_thresh_i,
  input  logic [CACHE_W-1:0] host_thresh_i,
  input  logic [CACHE_W-1:0] wb_thresh_i,
  output logic               force_wb_o,
  output logic               thr_wb_o,
  output logic               prefetch_o,
  output logic               fetch_o,
  output logic               stop_o
);
  logic [LEN_W-1:0] unused_ext, host_ext, host_side;
  logic             ring_empty, cache_empty, left_ahead;

  assign unused_ext  = LEN_W'(cache_unused_i);
  assign host_ext    = LEN_W'(host_thresh_i);
  assign ring_empty  = (desc_left_i == '0);
  assign cache_empty = (cache_unused_i == '0);
  // guard against wrap when left < unused
  assign left_ahead  = (desc_left_i > unused_ext);
  assign host_side   = desc_left_i - unused_ext;

  assign force_wb_o  = ring_empty;
  assign thr_wb_o    = (wb_thresh_i >= cache_used_i);
  assign prefetch_o  = (cache_unused_i < pf_thresh_i) && left_ahead && (host_side > host_ext);
  assign fetch_o     = cache_empty;
  assign stop_o      = ring_empty || cache_empty;
endmodule

// File: rtl/rx_ring_monitor.sv
module rx_ring_monitor
  import rx_ring_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned CACHE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_done_i,
  input  logic [LEN_W-1:0]   ring_len_i,
  input  logic [LEN_W-1:0]   desc_left_i,
  input  logic [CACHE_W-1:0] cache_used_i,
  input  logic [CACHE_W-1:0] cache_unused_i,
  input  logic [1:0]         min_sel_i,
  input  logic [CACHE_W-1:0] pf_thresh_i,
  input  logic [CACHE_W-1:0] host_thresh_i,
  input  logic [CACHE_W-1:0] wb_thresh_i,
  output logic               low_irq_o,
  output logic               force_wb_o,
  output logic               thr_wb_o,
  output logic               prefetch_o,
  output logic               fetch_o,
  output logic               stop_o
);
  ring_req_t req_d, req_q;

  ring_lowmark #(.LEN_W(LEN_W)) u_lowmark (
    .ring_len_i  (ring_len_i),
    .desc_left_i (desc_left_i),
    .min_sel_i   (min_sel_i),
    .low_o       (req_d.low_irq)
  );

  ring_cache_policy #(.LEN_W(LEN_W), .CACHE_W(CACHE_W)) u_policy (
    .desc_left_i    (desc_left_i),
    .cache_used_i   (cache_used_i),
    .cache_unused_i (cache_unused_i),
    .pf_thresh_i    (pf_thresh_i),
    .host_thresh_i  (host_thresh_i),
    .wb_thresh_i    (wb_thresh_i),
    .force_wb_o     (req_d.force_wb),
    .thr_wb_o       (req_d.thr_wb),
    .prefetch_o     (req_d.prefetch),
    .fetch_o        (req_d.fetch),
    .stop_o         (req_d.stop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         req_q <= '0;
    else if (pkt_done_i) req_q <= req_d;
    else                 req_q <= '0;
  end

  assign low_irq_o  = req_q.low_irq;
  assign force_wb_o = req_q.force_wb;
  assign thr_wb_o   = req_q.thr_wb;
  assign prefetch_o = req_q.prefetch;
  assign fetch_o    = req_q.fetch;
  assign stop_o     = req_q.stop;
endmodule

// File: rtl/rx_ring_monitor_chk.sv
module rx_ring_monitor_chk #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned CACHE_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pkt_done_i,
  input logic [LEN_W-1:0]   desc_left_i,
  input logic [CACHE_W-1:0] cache_used_i,
  input logic [CACHE_W-1:0] cache_unused_i,
  input logic [1:0]         min_sel_i,
  input logic [CACHE_W-1:0] pf_thresh_i,
  input logic [CACHE_W-1:0] wb_thresh_i,
  input logic               low_irq_o,
  input logic               force_wb_o,
  input logic               thr_wb_o,
  input logic               prefetch_o,
  input logic               fetch_o,
  input logic               stop_o
);
  logic any_req;
  assign any_req = low_irq_o | force_wb_o | thr_wb_o | prefetch_o | fetch_o | stop_o;

  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_done_i |=> !any_req);

  p_sel_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i && min_sel_i == 2'd3) |=> !low_irq_o);

  p_ring_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i && desc_left_i == '0) |=> (force_wb_o && stop_o));

  p_thr_wb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i && wb_thresh_i >= cache_used_i) |=> thr_wb_o);

  p_no_pf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i && cache_unused_i >= pf_thresh_i) |=> !prefetch_o);

  p_cache_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i && cache_unused_i == '0) |=> (fetch_o && stop_o));
endmodule

bind rx_ring_monitor rx_ring_monitor_chk #(.LEN_W(LEN_W), .CACHE_W(CACHE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pkt_done_i     (pkt_done_i),
  .desc_left_i    (desc_left_i),
  .cache_used_i   (cache_used_i),
  .cache_unused_i (cache_unused_i),
  .min_sel_i      (min_sel_i),
  .pf_thresh_i    (pf_thresh_i),
  .wb_thresh_i    (wb_thresh_i),
  .low_irq_o      (low_irq_o),
  .force_wb_o     (force_wb_o),
  .thr_wb_o       (thr_wb_o),
  .prefetch_o     (prefetch_o),
  .fetch_o        (fetch_o),
  .stop_o         (stop_o)
);

// File: tb/rx_ring_monitor_tb.sv
`timescale 1ns/1ps
module rx_ring_monitor_tb;
  localparam int unsigned LEN_W   = 16;
  localparam int unsigned CACHE_W = 6;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               pkt_done = 1'b0;
  logic [LEN_W-1:0]   ring_len = '0;
  logic [LEN_W-1:0]   desc_left = '0;
  logic [CACHE_W-1:0] used = '0, unused = '0, pf = '0, host = '0, wb = '0;
  logic [1:0]         sel = '0;
  logic low_irq, force_wb, thr_wb, prefetch, fetch, stop;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_ring_monitor #(.LEN_W(LEN_W), .CACHE_W(CACHE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pkt_done_i(pkt_done),
    .ring_len_i(ring_len), .desc_left_i(desc_left),
    .cache_used_i(used), .cache_unused_i(unused), .min_sel_i(sel),
    .pf_thresh_i(pf), .host_thresh_i(host), .wb_thresh_i(wb),
    .low_irq_o(low_irq), .force_wb_o(force_wb), .thr_wb_o(thr_wb),
    .prefetch_o(prefetch), .fetch_o(fetch), .stop_o(stop)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b len=%0d left=%0d sel=%0d used=%0d unused=%0d pf=%0d host=%0d wb=%0d",
               tag, got, exp, ring_len, desc_left, sel, used, unused, pf, host, wb);
    end
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " low"},      low_irq,  1'b0);
    chk({tag, " force_wb"}, force_wb, 1'b0);
    chk({tag, " thr_wb"},   thr_wb,   1'b0);
    chk({tag, " prefetch"}, prefetch, 1'b0);
    chk({tag, " fetch"},    fetch,    1'b0);
    chk({tag, " stop"},     stop,     1'b0);
  endtask

  task automatic apply(input int len, input int left, input int s, input int u, input int w,
                       input int un, input int p, input int h);
    int ml, frac, d;
    logic e_low, e_pf;
    @(negedge clk);
    ring_len = LEN_W'(len); desc_left = LEN_W'(left); sel = 2'(s);
    used = CACHE_W'(u); wb = CACHE_W'(w); unused = CACHE_W'(un);
    pf = CACHE_W'(p); host = CACHE_W'(h);
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
    ml = (len / 128) * 128;  // R4: low 7 bits ignored
    frac = (s == 0) ? ml / 2 : (s == 1) ? ml / 4 : ml / 8;
    e_low = (s != 3) && (left <= frac);
    d = left - un;
    e_pf = (un < p) && (d > h);
    chk((s == 3) ? "R3 low_off" : "R2 low_frac", low_irq, e_low);
    chk("R5 force_wb", force_wb, left == 0);
    chk("R6 thr_wb", thr_wb, w >= u);
    chk("R7 prefetch", prefetch, e_pf);
    chk("R8 fetch", fetch, un == 0);
    chk("R5_R8 stop", stop, (left == 0) || (un == 0));
    @(negedge clk);
    chk_quiet("R1 pulse_end");
  endtask

  initial begin
    int lens[4];
    lens[0] = 128; lens[1] = 200; lens[2] = 256; lens[3] = 1100;
    repeat (3) @(negedge clk);
    chk_quiet("R1 reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk_quiet("R1 idle");
    for (int s = 0; s < 4; s++)
      for (int li = 0; li < 4; li++)
        for (int lv = 0; lv < 6; lv++) begin
          int ml, frac, left;
          ml = (lens[li] / 128) * 128;
          frac = (s == 0 || s == 3) ? ml / 2 : (s == 1) ? ml / 4 : ml / 8;
          case (lv)
            0: left = 0;
            1: left = 1;
            2: left = 3;
            3: left = frac - 1;
            4: left = frac;
            default: left = frac + 1;
          endcase
          for (int uw = 0; uw < 12; uw++)
            for (int cp = 0; cp < 48; cp++)
              apply(lens[li], left, s, uw / 3, uw % 3, cp / 12, (cp / 3) % 4, cp % 3);
        end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule